// File: doc/BRIEF.md
# Power-Fail Status Register Unit

This block records platform power and reset failures as sticky status bits that firmware reads after a restart and clears by writing ones. It watches a reset button, a processor thermal-trip line, the platform reset, the processor regulator power-good, the main power-good, the deep-sleep control line, the resume-well reset and a core-well reset pulse. It also receives a slow real-time-clock tick enable and the current sleep state from the power sequencer. Each asynchronous input passes through a two-flop synchronizer into the register clock, and events are taken as edges of the synchronized levels.

A minimum-width timer guards the deep-sleep control line. The timer is armed when the line asserts while the sequencer is in S4 or S5, or when the resume-well reset is released on leaving G3. It counts slow-clock ticks up to a limit picked by a two-bit field. If the deep-sleep line drops before the limit is reached, a violation bit is set. A small register port gives access to the status word and the width select. The block's own flops are reset by a power-on reset that is separate from the resume-well reset, so that the power-good failure bit survives a resume-well reset.

Top module: `pwr_fail_status`

## Requirements
- R1: After power-on reset, both registers read zero: status at address 0 and control at address 1.
- R2: A press of the reset button (rising edge of the synchronized input) sets status bit 0. The bit is cleared by a core-reset pulse, while the resume-well reset is asserted, or by writing 1 to it.
- R3: A rising thermal-trip edge sets status bit 1 only while the platform reset is inactive. A later platform-reset assertion leaves the bit set. A core-reset pulse, the resume-well reset, or a write of 1 clears it.
- R4: Regulator power-good is sampled only in cycles with the slow tick. Status bit 3 sets when a sample is low, the previous sample was high, and the sleep state is S0 (code 0) or S1 (code 1). A low pulse that falls entirely between two ticks is missed, and a fall in any other state is ignored.
- R5: A falling edge of main power-good in S0 or S1 sets status bit 4. A fall in any other state does not set it. Only a write of 1 or entry into G3 (sleep code 7) clears the bit. Core reset and resume-well reset leave it unchanged.
- R6: Deep-sleep assertion in S4 (code 4) or S5 (code 5) arms the timer with a limit of (select+1) times TICKS_PER_SEC slow ticks, so select values 0 to 3 mean 1 to 4 seconds. A deep-sleep drop before the limit sets status bit 2. An assertion in S0 does not arm the timer.
- R7: A deep-sleep drop after the armed limit has been counted leaves status bit 2 clear.
- R8: Release of the resume-well reset also arms the timer. An early deep-sleep drop then sets status bit 2, and a drop after the limit does not.
- R9: A status write clears exactly the bits written as 1. Bits written as 0 keep their value. A hardware set in the same cycle as a clear wins.
- R10: Control register bits [1:0] hold the width select and can be read back. Data width is 5 bits, and the unused control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| por_rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_btn_i | input | 1 | Reset button pressed (active high, asynchronous) |
| therm_trip_i | input | 1 | Processor thermal trip (active high, asynchronous) |
| plat_rst_i | input | 1 | Platform reset asserted (active high, asynchronous) |
| vreg_pgood_i | input | 1 | Processor regulator power-good (asynchronous) |
| main_pgood_i | input | 1 | Main power-good (asynchronous) |
| deep_sleep_i | input | 1 | Monitored deep-sleep control, 1 = asserted (asynchronous) |
| rsm_rst_i | input | 1 | Resume-well reset asserted (active high, asynchronous) |
| core_rst_i | input | 1 | Core-well reset pulse, synchronous to clk_i |
| rtc_tick_i | input | 1 | Slow-clock tick enable, one cycle wide |
| sleep_state_i | input | 3 | Sleep state: 0 S0, 1 S1, 3 S3, 4 S4, 5 S5, 7 G3 |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register address: 0 status, 1 control |
| bus_wdata_i | input | 5 | Write data |
| bus_rdata_o | output | 5 | Read data for bus_addr_i, combinational |

## Verification
The assertions check on every cycle that a set pulse always lands in its status bit, that a status write clears the written bits unless a set arrives in the same cycle, that the power-good failure bit falls only after a write or a G3 entry, that thermal and width-violation bits rise only from their qualified events, and that the timer count never passes its latched limit. Only the bench scenarios can show which sleep states qualify each event, that a regulator dip between ticks is missed, and that the arming paths and the select field set the real violation window. They also show that core and resume-well resets leave the power-good bit alone.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    localparam int STS_W = 5;

    localparam int STS_BTN   = 0;
    localparam int STS_THERM = 1;
    localparam int STS_WIDTH = 2;
    localparam int STS_VREG  = 3;
    localparam int STS_PG    = 4;

    localparam int SY_BTN   = 0;
    localparam int SY_THERM = 1;
    localparam int SY_PLAT  = 2;
    localparam int SY_VREG  = 3;
    localparam int SY_PG    = 4;
    localparam int SY_DS    = 5;
    localparam int SY_RSM   = 6;
    localparam int N_SYNC   = 7;

    localparam logic ADDR_STS = 1'b0;
    localparam logic ADDR_CTL = 1'b1;

    typedef enum logic [2:0] {
        SL_S0 = 3'd0,
        SL_S1 = 3'd1,
        SL_S3 = 3'd3,
        SL_S4 = 3'd4,
        SL_S5 = 3'd5,
        SL_G3 = 3'd7
    } sleep_e;

    function automatic logic is_working(input logic [2:0] st);
        return (st == SL_S0) || (st == SL_S1);
    endfunction

    function automatic logic is_deep(input logic [2:0] st);
        return (st == SL_S4) || (st == SL_S5);
    endfunction

endpackage

// File: rtl/pfs_sync_bank.sv
module pfs_sync_bank #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic [STAGES-1:0] chain_d, chain_q;

            always_comb begin
                chain_d = {chain_q[STAGES-2:0], async_i[g]};
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= chain_d;
            end

            assign sync_o[g] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pfs_event_logic.sv
module pfs_event_logic
    import pfs_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_SYNC-1:0] sync_i,
    input  logic              core_rst_i,
    input  logic              rtc_tick_i,
    input  logic [2:0]        sleep_state_i,
    input  logic              width_viol_i,
    output logic [STS_W-1:0]  set_o,
    output logic [STS_W-1:0]  hw_clr_o,
    output logic              arm_o,
    output logic              ds_fall_o,
    output logic              therm_rise_o
);

    typedef struct packed {
        logic       vreg_smp;
        logic [2:0] prev_state;
        logic       btn;
        logic       therm;
        logic       pg;
        logic       ds;
        logic       rsm;
    } ev_state_t;

    ev_state_t st_d, st_q;

    logic btn_rise, therm_rise, pg_fall, ds_rise, ds_fall, rsm_fall;
    logic vreg_fall, g3_entry;

    always_comb begin
        st_d            = st_q;
        st_d.btn        = sync_i[SY_BTN];
        st_d.therm      = sync_i[SY_THERM];
        st_d.pg         = sync_i[SY_PG];
        st_d.ds         = sync_i[SY_DS];
        st_d.rsm        = sync_i[SY_RSM];
        st_d.prev_state = sleep_state_i;
        if (rtc_tick_i) st_d.vreg_smp = sync_i[SY_VREG];

        btn_rise   = sync_i[SY_BTN]   & ~st_q.btn;
        therm_rise = sync_i[SY_THERM] & ~st_q.therm;
        pg_fall    = ~sync_i[SY_PG]   &  st_q.pg;
        ds_rise    = sync_i[SY_DS]    & ~st_q.ds;
        ds_fall    = ~sync_i[SY_DS]   &  st_q.ds;
        rsm_fall   = ~sync_i[SY_RSM]  &  st_q.rsm;
        vreg_fall  = rtc_tick_i & st_q.vreg_smp & ~sync_i[SY_VREG];
        g3_entry   = (sleep_state_i == SL_G3) && (st_q.prev_state != SL_G3);

        set_o            = '0;
        set_o[STS_BTN]   = btn_rise;
        set_o[STS_THERM] = therm_rise & ~sync_i[SY_PLAT];
        set_o[STS_WIDTH] = width_viol_i;
        set_o[STS_VREG]  = vreg_fall & is_working(sleep_state_i);
        set_o[STS_PG]    = pg_fall   & is_working(sleep_state_i);

        hw_clr_o            = '0;
        hw_clr_o[STS_BTN]   = core_rst_i | sync_i[SY_RSM];
        hw_clr_o[STS_THERM] = core_rst_i | sync_i[SY_RSM];
        hw_clr_o[STS_WIDTH] = sync_i[SY_RSM];
        hw_clr_o[STS_VREG]  = sync_i[SY_RSM];
        hw_clr_o[STS_PG]    = g3_entry;

        arm_o        = (ds_rise & is_deep(sleep_state_i)) | rsm_fall;
        ds_fall_o    = ds_fall;
        therm_rise_o = therm_rise;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/pfs_width_timer.sv
module pfs_width_timer #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int CNT_W         = $clog2(4 * TICKS_PER_SEC + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rtc_tick_i,
    input  logic             arm_i,
    input  logic             ds_fall_i,
    input  logic [1:0]       sel_i,
    output logic             viol_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] limit_o
);

    typedef struct packed {
        logic             running;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] limit;
    } tmr_t;

    tmr_t t_d, t_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        t_d     = t_q;
        viol_o  = 1'b0;
        cnt_inc = t_q.cnt + CNT_W'(1);
        if (arm_i) begin
            t_d.running = 1'b1;
            t_d.cnt     = '0;
            t_d.limit   = CNT_W'(TICKS_PER_SEC) * (CNT_W'(sel_i) + CNT_W'(1));
        end else if (t_q.running) begin
            if (ds_fall_i) begin
                t_d.running = 1'b0;
                viol_o      = 1'b1;
            end else if (rtc_tick_i) begin
                t_d.cnt = cnt_inc;
                if (cnt_inc >= t_q.limit) t_d.running = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    assign cnt_o   = t_q.cnt;
    assign limit_o = t_q.limit;

endmodule

// File: rtl/pfs_regfile.sv
module pfs_regfile
    import pfs_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bus_wr_i,
    input  logic             bus_addr_i,
    input  logic [STS_W-1:0] bus_wdata_i,
    input  logic [STS_W-1:0] set_i,
    input  logic [STS_W-1:0] hw_clr_i,
    output logic [STS_W-1:0] sts_o,
    output logic [1:0]       sel_o,
    output logic [STS_W-1:0] bus_rdata_o
);

    typedef struct packed {
        logic [STS_W-1:0] sts;
        logic [1:0]       sel;
    } regs_t;

    regs_t r_d, r_q;
    logic [STS_W-1:0] sw_clr;

    always_comb begin
        r_d    = r_q;
        sw_clr = (bus_wr_i && bus_addr_i == ADDR_STS) ? bus_wdata_i : '0;
        r_d.sts = (r_q.sts & ~(sw_clr | hw_clr_i)) | set_i;
        if (bus_wr_i && bus_addr_i == ADDR_CTL) r_d.sel = bus_wdata_i[1:0];

        bus_rdata_o = (bus_addr_i == ADDR_STS) ? r_q.sts
                                               : {{(STS_W-2){1'b0}}, r_q.sel};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign sts_o = r_q.sts;
    assign sel_o = r_q.sel;

endmodule

// File: rtl/pwr_fail_status.sv
module pwr_fail_status
    import pfs_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk_i,
    input  logic             por_rst_ni,
    input  logic             rst_btn_i,
    input  logic             therm_trip_i,
    input  logic             plat_rst_i,
    input  logic             vreg_pgood_i,
    input  logic             main_pgood_i,
    input  logic             deep_sleep_i,
    input  logic             rsm_rst_i,
    input  logic             core_rst_i,
    input  logic             rtc_tick_i,
    input  logic [2:0]       sleep_state_i,
    input  logic             bus_wr_i,
    input  logic             bus_addr_i,
    input  logic [STS_W-1:0] bus_wdata_i,
    output logic [STS_W-1:0] bus_rdata_o
);

    localparam int CNT_W = $clog2(4 * TICKS_PER_SEC + 1);

    logic [N_SYNC-1:0] async_vec, sync_vec;
    logic [STS_W-1:0]  set_vec, hw_clr_vec, sts_q;
    logic [1:0]        sel_q;
    logic              arm, ds_fall, therm_rise, width_viol;
    logic [CNT_W-1:0]  tmr_cnt, tmr_limit;

    always_comb begin
        async_vec           = '0;
        async_vec[SY_BTN]   = rst_btn_i;
        async_vec[SY_THERM] = therm_trip_i;
        async_vec[SY_PLAT]  = plat_rst_i;
        async_vec[SY_VREG]  = vreg_pgood_i;
        async_vec[SY_PG]    = main_pgood_i;
        async_vec[SY_DS]    = deep_sleep_i;
        async_vec[SY_RSM]   = rsm_rst_i;
    end

    pfs_sync_bank #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (por_rst_ni),
        .async_i (async_vec),
        .sync_o  (sync_vec)
    );

    pfs_event_logic u_events (
        .clk_i         (clk_i),
        .rst_ni        (por_rst_ni),
        .sync_i        (sync_vec),
        .core_rst_i    (core_rst_i),
        .rtc_tick_i    (rtc_tick_i),
        .sleep_state_i (sleep_state_i),
        .width_viol_i  (width_viol),
        .set_o         (set_vec),
        .hw_clr_o      (hw_clr_vec),
        .arm_o         (arm),
        .ds_fall_o     (ds_fall),
        .therm_rise_o  (therm_rise)
    );

    pfs_width_timer #(.TICKS_PER_SEC(TICKS_PER_SEC), .CNT_W(CNT_W)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (por_rst_ni),
        .rtc_tick_i (rtc_tick_i),
        .arm_i      (arm),
        .ds_fall_i  (ds_fall),
        .sel_i      (sel_q),
        .viol_o     (width_viol),
        .cnt_o      (tmr_cnt),
        .limit_o    (tmr_limit)
    );

    pfs_regfile u_regs (
        .clk_i       (clk_i),
        .rst_ni      (por_rst_ni),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .set_i       (set_vec),
        .hw_clr_i    (hw_clr_vec),
        .sts_o       (sts_q),
        .sel_o       (sel_q),
        .bus_rdata_o (bus_rdata_o)
    );

endmodule

// File: rtl/pfs_checker.sv
module pfs_checker
    import pfs_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input logic             clk_i,
    input logic             por_rst_ni,
    input logic             bus_wr_i,
    input logic             bus_addr_i,
    input logic [STS_W-1:0] bus_wdata_i,
    input logic [2:0]       sleep_state_i,
    input logic [STS_W-1:0] sts,
    input logic [STS_W-1:0] set_vec,
    input logic             ds_fall,
    input logic             therm_rise,
    input logic             plat_sync,
    input logic [CNT_W-1:0] tmr_cnt,
    input logic [CNT_W-1:0] tmr_limit
);

    logic sts_wr;
    assign sts_wr = bus_wr_i && (bus_addr_i == ADDR_STS);

    a_r9_set_is_sticky: assert property (@(posedge clk_i) disable iff (!por_rst_ni)
        (set_vec != '0) |=> ((sts & $past(set_vec)) == $past(set_vec)));

    a_r9_write_one_clears: assert property (@(posedge clk_i) disable iff (!por_rst_ni)
        sts_wr |=> ((sts & $past(bus_wdata_i & ~set_vec)) == '0));

    a_r5_pg_clear_sources: assert property (@(posedge clk_i) disable iff (!por_rst_ni)
        $fell(sts[STS_PG]) |->
            ($past(sts_wr && bus_wdata_i[STS_PG]) ||
             ($past(sleep_state_i) == SL_G3 && $past(sleep_state_i, 2) != SL_G3)));

    a_r3_therm_qualified: assert property (@(posedge clk_i) disable iff (!por_rst_ni)
        $rose(sts[STS_THERM]) |-> $past(therm_rise && !plat_sync));

    a_r6_viol_needs_drop: assert property (@(posedge clk_i) disable iff (!por_rst_ni)
        $rose(sts[STS_WIDTH]) |-> $past(ds_fall));

    a_r6_count_in_limit: assert property (@(posedge clk_i) disable iff (!por_rst_ni)
        tmr_cnt <= tmr_limit);

endmodule

bind pwr_fail_status pfs_checker #(.CNT_W(CNT_W)) u_pfs_chk (
    .clk_i         (clk_i),
    .por_rst_ni    (por_rst_ni),
    .bus_wr_i      (bus_wr_i),
    .bus_addr_i    (bus_addr_i),
    .bus_wdata_i   (bus_wdata_i),
    .sleep_state_i (sleep_state_i),
    .sts           (sts_q),
    .set_vec       (set_vec),
    .ds_fall       (ds_fall),
    .therm_rise    (therm_rise),
    .plat_sync     (sync_vec[pfs_pkg::SY_PLAT]),
    .tmr_cnt       (tmr_cnt),
    .tmr_limit     (tmr_limit)
);

// File: tb/pwr_fail_status_tb_top.sv
module pwr_fail_status_tb_top;

    logic       clk = 1'b0;
    logic       por_rst_n = 1'b0;
    logic       rst_btn = 0, therm = 0, plat = 0, vreg = 1, pg = 1, ds = 0, rsm = 0;
    logic       core_rst = 0, tick = 0;
    logic [2:0] state = 3'd0;
    logic       wr = 0;
    logic       addr = 0;
    logic [4:0] wdata = '0;
    logic [4:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwr_fail_status #(.TICKS_PER_SEC(4)) dut_i (
        .clk_i(clk), .por_rst_ni(por_rst_n),
        .rst_btn_i(rst_btn), .therm_trip_i(therm), .plat_rst_i(plat),
        .vreg_pgood_i(vreg), .main_pgood_i(pg), .deep_sleep_i(ds),
        .rsm_rst_i(rsm), .core_rst_i(core_rst), .rtc_tick_i(tick),
        .sleep_state_i(state), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [4:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wr_reg(input logic a, input logic [4:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic check_sts(input string req, input logic [4:0] exp);
        logic [4:0] v;
        rd(1'b0, v);
        check(req, v, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; @(negedge clk);
            tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic pulse_core;
        core_rst = 1'b1; @(negedge clk); core_rst = 1'b0; wait_cyc(2);
    endtask

    task automatic t_reset;
        logic [4:0] v;
        check_sts("R1 status after reset", 5'h00);
        rd(1'b1, v);
        check("R1 control after reset", v, 5'h00);
    endtask

    task automatic t_button;
        rst_btn = 1; wait_cyc(5); rst_btn = 0; wait_cyc(5);
        check_sts("R2 button sets bit0", 5'h01);
        wr_reg(1'b0, 5'h00); wait_cyc(1);
        check_sts("R9 write 0 keeps bit0", 5'h01);
        wr_reg(1'b0, 5'h01); wait_cyc(1);
        check_sts("R2 write 1 clears bit0", 5'h00);
        rst_btn = 1; wait_cyc(5); rst_btn = 0; wait_cyc(5);
        pulse_core;
        check_sts("R2 core reset clears bit0", 5'h00);
        rst_btn = 1; wait_cyc(5); rst_btn = 0; wait_cyc(5);
        rsm = 1; wait_cyc(5);
        check_sts("R2 resume reset clears bit0", 5'h00);
        rsm = 0; wait_cyc(5);
    endtask

    task automatic t_thermal;
        plat = 1; wait_cyc(5); therm = 1; wait_cyc(5);
        check_sts("R3 trip ignored in platform reset", 5'h00);
        therm = 0; plat = 0; wait_cyc(5);
        therm = 1; wait_cyc(5);
        check_sts("R3 trip sets bit1", 5'h02);
        plat = 1; wait_cyc(5);
        check_sts("R3 shutdown keeps bit1", 5'h02);
        rst_btn = 1; wait_cyc(5); rst_btn = 0; wait_cyc(5);
        wr_reg(1'b0, 5'h01); wait_cyc(1);
        check_sts("R9 write clears only bit0", 5'h02);
        pulse_core;
        check_sts("R3 core reset clears bit1", 5'h00);
        therm = 0; plat = 0; wait_cyc(5);
    endtask

    task automatic t_vreg;
        state = 3'd0; vreg = 1; wait_cyc(4); ticks(1);
        vreg = 0; wait_cyc(5); vreg = 1; wait_cyc(5); ticks(1);
        check_sts("R4 dip between ticks missed", 5'h00);
        vreg = 0; wait_cyc(5); ticks(1); wait_cyc(1);
        check_sts("R4 sampled fall sets bit3", 5'h08);
        vreg = 1; wait_cyc(5); ticks(1);
        wr_reg(1'b0, 5'h08); wait_cyc(1);
        state = 3'd3;
        vreg = 0; wait_cyc(5); ticks(1); wait_cyc(1);
        check_sts("R4 fall in S3 ignored", 5'h00);
        vreg = 1; wait_cyc(5); ticks(1); state = 3'd0;
    endtask

    task automatic t_pgood;
        state = 3'd1; pg = 0; wait_cyc(5);
        check_sts("R5 pg fall in S1 sets bit4", 5'h10);
        pg = 1; wait_cyc(5);
        pulse_core;
        check_sts("R5 core reset keeps bit4", 5'h10);
        rsm = 1; wait_cyc(5); rsm = 0; wait_cyc(5);
        check_sts("R5 resume reset keeps bit4", 5'h10);
        state = 3'd7; wait_cyc(2);
        check_sts("R5 G3 entry clears bit4", 5'h00);
        state = 3'd3; wait_cyc(2); pg = 0; wait_cyc(5);
        check_sts("R5 pg fall in S3 ignored", 5'h00);
        pg = 1; state = 3'd0; wait_cyc(5);
    endtask

    task automatic t_width;
        logic [4:0] v;
        wr_reg(1'b1, 5'h1F); rd(1'b1, v);
        check("R10 control readback masked", v, 5'h03);
        wr_reg(1'b1, 5'h00); rd(1'b1, v);
        check("R10 control readback zero", v, 5'h00);
        state = 3'd4; ds = 1; wait_cyc(5); ticks(2); ds = 0; wait_cyc(5);
        check_sts("R6 early drop sel0 sets bit2", 5'h04);
        wr_reg(1'b0, 5'h04); wr_reg(1'b1, 5'h01);
        state = 3'd5; ds = 1; wait_cyc(5); ticks(6); ds = 0; wait_cyc(5);
        check_sts("R6 drop at 6 of 8 ticks sets bit2", 5'h04);
        wr_reg(1'b0, 5'h04);
        ds = 1; wait_cyc(5); ticks(9); ds = 0; wait_cyc(5);
        check_sts("R7 late drop no violation", 5'h00);
        state = 3'd0; ds = 1; wait_cyc(5); ds = 0; wait_cyc(5);
        check_sts("R6 assert in S0 does not arm", 5'h00);
    endtask

    task automatic t_g3_exit;
        state = 3'd7; rsm = 1; ds = 1; wait_cyc(5);
        rsm = 0; wait_cyc(5); ticks(1); ds = 0; wait_cyc(5);
        check_sts("R8 early drop after G3 exit", 5'h04);
        wr_reg(1'b0, 5'h04);
        rsm = 1; ds = 1; wait_cyc(5);
        rsm = 0; wait_cyc(5); ticks(9); ds = 0; wait_cyc(5);
        check_sts("R8 late drop after G3 exit", 5'h00);
        state = 3'd0; wait_cyc(2);
    endtask

    initial begin
        wait_cyc(4);
        por_rst_n = 1'b1;
        wait_cyc(4);
        t_reset;
        t_button;
        t_thermal;
        t_vreg;
        t_pgood;
        t_width;
        t_g3_exit;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule